// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns two incremental-encoder signals into a signed-free position count that moves up or down by one per decoded step. Each encoder line first crosses into the clock domain through two flops. It can then be inverted, and it can optionally be cleaned by a stability filter whose window the caller programs. The conditioned lines are decoded in one of two ways. In quadrature mode, every edge of either line is a step, and the direction comes from the order of the edges. In count/direction mode, one line supplies the steps and the other gives the direction.

The position register runs between a lower bound and an upper bound, both programmable. Stepping past either bound reloads the opposite bound. It also sets a sticky overflow flag and records whether the wrap occurred at the top or at the bottom. A direction output shows which way the most recent counted step went. An enable input freezes counting. Software or a neighbouring block clears the overflow flag with a one-cycle pulse.

Top module: `qdec_counter`

## Requirements
- R1: While reset is high, and on the first cycle after it, the count equals `i_min`, `o_dir_up` is 1, and `o_ovf` and `o_ovf_top` are 0.
- R2: Each phase pin is inverted when its invert bit is 1, and this happens before any edge is decoded. With its filter inactive, a pin change reaches `o_count` on the 4th rising clock edge after the change.
- R3: A filter acts only when its enable bit is 1 and its length L is nonzero. When it acts, a new level is accepted once the input has held that level for 4*L consecutive clocks. With L=2, a pulse of 7 clocks is dropped and a pulse of 8 clocks passes. With L=0, or with the enable at 0, a pulse of 2 clocks passes.
- R4: With `i_mode`=0, decoding is 4x. For the (A,B) level pairs 00→10→11→01→00, each transition counts up by one. The reverse order counts down by one.
- R5: With `i_mode`=0, a transition in which both conditioned phases change in the same cycle does not change the count.
- R6: With `i_mode`=1, each rising edge of conditioned A counts up when conditioned B is 1 and down when it is 0. Falling edges of A and any change of B do not count.
- R7: An up step taken with the count at or above `i_max` loads `i_min`, sets `o_ovf`, and sets `o_ovf_top` to 1.
- R8: A down step taken with the count at or below `i_min` loads `i_max`, sets `o_ovf`, and sets `o_ovf_top` to 0.
- R9: `o_dir_up` becomes 1 after a counted up step and 0 after a counted down step. It holds its value otherwise.
- R10: While `i_en` is 0, the count and the direction output hold. Edges that arrive while it is 0 are never counted later.
- R11: `o_ovf` stays set until `i_ovf_clr` is sampled high. A wrap in the same cycle as a clear leaves `o_ovf` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_pha | input | 1 | Encoder line A (asynchronous) |
| i_phb | input | 1 | Encoder line B (asynchronous) |
| i_en | input | 1 | Counting enable |
| i_mode | input | 1 | 0 = quadrature, 1 = count/direction |
| i_inv_a | input | 1 | Invert line A |
| i_inv_b | input | 1 | Invert line B |
| i_flt_en_a | input | 1 | Filter enable, line A |
| i_flt_en_b | input | 1 | Filter enable, line B |
| i_flt_len_a | input | FLT_W | Filter length, line A (window 4*L clocks) |
| i_flt_len_b | input | FLT_W | Filter length, line B |
| i_min | input | CNT_W | Lower count bound |
| i_max | input | CNT_W | Upper count bound |
| i_ovf_clr | input | 1 | Overflow flag clear pulse |
| o_count | output | CNT_W | Position count |
| o_dir_up | output | 1 | Direction of last counted step (1 = up) |
| o_ovf | output | 1 | Sticky wrap flag |
| o_ovf_top | output | 1 | 1 = last wrap at top, 0 = at bottom |

## Verification
The wrap properties compare the reloaded count against the bound as it stood one cycle earlier. They therefore rely on the bounds holding steady across a counted step, and the stimulus sets the bounds once, before counting starts. Changing an invert bit, the mode or a filter setting looks to the decoder like a pin edge. For that reason the bench changes configuration only while `i_en` is 0, and it waits out the synchronizer and filter latency before enabling again. The illegal-transition property treats the conditioned phases one cycle earlier as the decoder's previous state. This holds because that state is updated every cycle whatever the enable.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic {
    MODE_AB     = 1'b0,
    MODE_CNTDIR = 1'b1
  } qdec_mode_e;

  typedef struct packed {
    logic valid;
    logic up;
  } qdec_step_t;

endpackage

// File: rtl/qdec_input_cond.sv
module qdec_input_cond #(
  parameter int FLT_W     = 4,
  parameter int FLT_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             invert,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] flt_len,
  output logic             level
);
  localparam int FCNT_W = FLT_W + FLT_SHIFT;

  logic              sync1, sync2;
  logic              lvl_in;
  logic              active;
  logic [FCNT_W-1:0] limit;
  logic [FCNT_W-1:0] run_cnt;

  // two-flop synchronizer on the raw pin
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
    end
  end

  // inversion happens before any edge logic downstream
  assign lvl_in = sync2 ^ invert;
  assign active = flt_en && (flt_len != '0);
  assign limit  = {flt_len, {FLT_SHIFT{1'b0}}} - {{(FCNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (!active) begin
      level   <= lvl_in;
      run_cnt <= '0;
    end else if (lvl_in == level) begin
      run_cnt <= '0;
    end else if (run_cnt == limit) begin
      level   <= lvl_in;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + {{(FCNT_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  qdec_mode_e mode,
  input  logic       ph_a,
  input  logic       ph_b,
  output qdec_step_t step
);
  logic prev_a, prev_b;
  logic chg_a, chg_b;

  // previous levels track every cycle so disabled edges are never replayed
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= ph_a;
      prev_b <= ph_b;
    end
  end

  assign chg_a = ph_a ^ prev_a;
  assign chg_b = ph_b ^ prev_b;

  always_comb begin
    step = '0;
    unique case (mode)
      MODE_AB: begin
        // exactly one phase moved; A leading B means up
        step.valid = chg_a ^ chg_b;
        step.up    = ph_a ^ prev_b;
      end
      MODE_CNTDIR: begin
        step.valid = ph_a & ~prev_a;
        step.up    = ph_b;
      end
      default: step = '0;
    endcase
  end

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  qdec_step_t       step,
  input  logic [CNT_W-1:0] lo_bound,
  input  logic [CNT_W-1:0] hi_bound,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             ovf,
  output logic             ovf_top
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic take;
  logic wrap_hi, wrap_lo;

  assign take    = en && step.valid;
  assign wrap_hi = take &&  step.up && (count >= hi_bound);
  assign wrap_lo = take && !step.up && (count <= lo_bound);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= lo_bound;
      dir_up  <= 1'b1;
      ovf     <= 1'b0;
      ovf_top <= 1'b0;
    end else begin
      if (take) begin
        dir_up <= step.up;
        if (step.up) count <= wrap_hi ? lo_bound : count + ONE;
        else         count <= wrap_lo ? hi_bound : count - ONE;
      end
      if (wrap_hi || wrap_lo) ovf_top <= wrap_hi;
      ovf <= (ovf && !ovf_clr) || wrap_hi || wrap_lo;
    end
  end

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FLT_W     = 4,
  parameter int FLT_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_pha,
  input  logic             i_phb,
  input  logic             i_en,
  input  logic             i_mode,
  input  logic             i_inv_a,
  input  logic             i_inv_b,
  input  logic             i_flt_en_a,
  input  logic             i_flt_en_b,
  input  logic [FLT_W-1:0] i_flt_len_a,
  input  logic [FLT_W-1:0] i_flt_len_b,
  input  logic [CNT_W-1:0] i_min,
  input  logic [CNT_W-1:0] i_max,
  input  logic             i_ovf_clr,
  output logic [CNT_W-1:0] o_count,
  output logic             o_dir_up,
  output logic             o_ovf,
  output logic             o_ovf_top
);
  localparam int NCH = 2;

  logic [NCH-1:0] ch_pin, ch_inv, ch_fen, ch_lvl;
  logic [FLT_W-1:0] ch_len [NCH];
  logic       lvl_a, lvl_b;
  qdec_step_t step;
  logic       step_valid, step_up;

  assign ch_pin    = {i_phb, i_pha};
  assign ch_inv    = {i_inv_b, i_inv_a};
  assign ch_fen    = {i_flt_en_b, i_flt_en_a};
  assign ch_len[0] = i_flt_len_a;
  assign ch_len[1] = i_flt_len_b;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qdec_input_cond #(.FLT_W(FLT_W), .FLT_SHIFT(FLT_SHIFT)) u_cond (
      .clk     (clk),
      .rst     (rst),
      .pin     (ch_pin[g]),
      .invert  (ch_inv[g]),
      .flt_en  (ch_fen[g]),
      .flt_len (ch_len[g]),
      .level   (ch_lvl[g])
    );
  end

  assign lvl_a = ch_lvl[0];
  assign lvl_b = ch_lvl[1];

  qdec_step_decode u_dec (
    .clk  (clk),
    .rst  (rst),
    .mode (qdec_mode_e'(i_mode)),
    .ph_a (lvl_a),
    .ph_b (lvl_b),
    .step (step)
  );

  assign step_valid = step.valid;
  assign step_up    = step.up;

  qdec_pos_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (i_en),
    .step     (step),
    .lo_bound (i_min),
    .hi_bound (i_max),
    .ovf_clr  (i_ovf_clr),
    .count    (o_count),
    .dir_up   (o_dir_up),
    .ovf      (o_ovf),
    .ovf_top  (o_ovf_top)
  );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             i_en,
  input logic             i_mode,
  input logic [CNT_W-1:0] i_min,
  input logic [CNT_W-1:0] i_max,
  input logic             i_ovf_clr,
  input logic [CNT_W-1:0] o_count,
  input logic             o_dir_up,
  input logic             o_ovf,
  input logic             o_ovf_top,
  input logic             lvl_a,
  input logic             lvl_b,
  input logic             step_valid,
  input logic             step_up
);

  p_up_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (i_en && step_valid && step_up && o_count >= i_max)
      |=> (o_count == $past(i_min) && o_ovf && o_ovf_top));

  p_dn_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (i_en && step_valid && !step_up && o_count <= i_min)
      |=> (o_count == $past(i_max) && o_ovf && !o_ovf_top));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !i_en |=> ($stable(o_count) && $stable(o_dir_up)));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (o_ovf && !i_ovf_clr) |=> o_ovf);

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (i_ovf_clr && !(i_en && step_valid)) |=> !o_ovf);

  p_illegal_r5: assert property (@(posedge clk) disable iff (rst)
    (!i_mode && lvl_a != $past(lvl_a) && lvl_b != $past(lvl_b)) |-> !step_valid);

  p_cntdir_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (i_mode && step_valid) |-> (lvl_a && !$past(lvl_a)));

  p_dir_r9: assert property (@(posedge clk) disable iff (rst)
    (i_en && step_valid) |=> (o_dir_up == $past(step_up)));

endmodule

bind qdec_counter qdec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .i_en       (i_en),
  .i_mode     (i_mode),
  .i_min      (i_min),
  .i_max      (i_max),
  .i_ovf_clr  (i_ovf_clr),
  .o_count    (o_count),
  .o_dir_up   (o_dir_up),
  .o_ovf      (o_ovf),
  .o_ovf_top  (o_ovf_top),
  .lvl_a      (lvl_a),
  .lvl_b      (lvl_b),
  .step_valid (step_valid),
  .step_up    (step_up)
);

// File: tb/sim_qdec_counter.sv
module sim_qdec_counter;
  localparam int CNT_W = 16;
  localparam int FLT_W = 4;
  localparam int LO = 5;
  localparam int HI = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pha = 1'b0, phb = 1'b0, en = 1'b0, mode = 1'b0;
  logic inv_a = 1'b0, inv_b = 1'b0, fen_a = 1'b0, fen_b = 1'b0;
  logic [FLT_W-1:0] len_a = '0, len_b = '0;
  logic [CNT_W-1:0] lo_b = CNT_W'(LO), hi_b = CNT_W'(HI);
  logic clr = 1'b0;
  logic [CNT_W-1:0] cnt;
  logic dir_up, ovf, ovf_top;

  int checks = 0, fails = 0;
  int exp_cnt = LO;
  bit exp_dir = 1'b1, exp_ovf = 1'b0, exp_top = 1'b0;
  int ab_state = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qdec_counter u0 (
    .clk(clk), .rst(rst), .i_pha(pha), .i_phb(phb), .i_en(en), .i_mode(mode),
    .i_inv_a(inv_a), .i_inv_b(inv_b), .i_flt_en_a(fen_a), .i_flt_en_b(fen_b),
    .i_flt_len_a(len_a), .i_flt_len_b(len_b), .i_min(lo_b), .i_max(hi_b),
    .i_ovf_clr(clr), .o_count(cnt), .o_dir_up(dir_up), .o_ovf(ovf),
    .o_ovf_top(ovf_top)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // model one counted step from the requirement text
  task automatic model(input bit up);
    exp_dir = up;
    if (up) begin
      if (exp_cnt >= HI) begin exp_cnt = LO; exp_ovf = 1'b1; exp_top = 1'b1; end
      else exp_cnt++;
    end else begin
      if (exp_cnt <= LO) begin exp_cnt = HI; exp_ovf = 1'b1; exp_top = 1'b0; end
      else exp_cnt--;
    end
  endtask

  // quadrature pair table: index 0..3 -> (A,B) = 00,10,11,01
  task automatic drive_ab(input int s);
    @(negedge clk);
    pha = (s == 1 || s == 2);
    phb = (s == 2 || s == 3);
    ab_state = s;
    idle(8);
  endtask

  task automatic check_all(input string req);
    check({req, " count"}, int'(cnt), exp_cnt);
    check({req, " dir"}, int'(dir_up), int'(exp_dir));
    check({req, " ovf"}, int'(ovf), int'(exp_ovf));
    check({req, " ovf_top"}, int'(ovf_top), int'(exp_top));
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_ovf = 1'b0;
  endtask

  task automatic pulse_a(input int width);
    @(negedge clk); pha = 1'b1;
    repeat (width) @(negedge clk);
    pha = 1'b0;
    idle(20);
  endtask

  task automatic pause();
    @(negedge clk); en = 1'b0;
  endtask

  task automatic resume();
    idle(10);
    en = 1'b1;
    idle(2);
  endtask

  initial begin
    idle(3);
    // R1: reset state while held and just after release
    check("R1 count in reset", int'(cnt), LO);
    @(negedge clk); rst = 1'b0;
    check_all("R1");
    resume();

    // R4 + R7 + R9: quadrature up across the top bound
    for (int i = 0; i < 10; i++) begin
      drive_ab((ab_state + 1) % 4);
      model(1'b1);
      check_all("R4/R7/R9 up");
    end
    pulse_clr();
    idle(1);
    check("R11 clear", int'(ovf), 0);

    // R4 + R8 + R9: quadrature down across the bottom bound
    for (int i = 0; i < 12; i++) begin
      drive_ab((ab_state + 3) % 4);
      model(1'b0);
      check_all("R4/R8/R9 down");
    end
    check("R8 wrap at bottom", int'(ovf_top), 0);
    pulse_clr();

    // R5: both phases in one cycle
    drive_ab((ab_state + 2) % 4);
    check_all("R5 illegal");
    drive_ab((ab_state + 1) % 4);
    model(1'b1);
    check_all("R5 after illegal");

    // R10: disabled edges are dropped, not deferred
    pause();
    for (int i = 0; i < 3; i++) begin
      drive_ab((ab_state + 3) % 4);
      check_all("R10 hold");
    end
    resume();
    check_all("R10 not replayed");

    // R2: inverted A turns an up order into down steps
    pause(); inv_a = 1'b1; resume();
    for (int i = 0; i < 3; i++) begin
      drive_ab((ab_state + 1) % 4);
      model(1'b0);
      check_all("R2 inverted A");
    end
    pause(); inv_a = 1'b0; resume();
    check_all("R2 restore");

    // R6: count/direction mode
    pause(); mode = 1'b1; pha = 1'b0; phb = 1'b1; resume();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pha = 1'b1; idle(8);
      model(1'b1);
      check_all("R6 rise up");
      @(negedge clk); pha = 1'b0; idle(8);
      check_all("R6 fall ignored");
    end
    @(negedge clk); phb = 1'b0; idle(8);
    check_all("R6 B change ignored");
    for (int i = 0; i < 3; i++) begin
      pulse_a(10);
      model(1'b0);
      check_all("R6 rise down");
    end

    // R2: inverted A in count/direction mode counts on pin falling edge
    pause(); inv_a = 1'b1; resume();
    check_all("R2 cd invert settle");
    @(negedge clk); pha = 1'b1; idle(8);
    check_all("R2 cd pin rise ignored");
    @(negedge clk); pha = 1'b0; idle(8);
    model(1'b0);
    check_all("R2 cd pin fall counts");
    pause(); inv_a = 1'b0; phb = 1'b1; resume();
    check_all("R2 cd restore");

    // R3: filter threshold at length 2 (window of 8 clocks)
    pause(); fen_a = 1'b1; len_a = 4'd2; resume();
    pulse_a(7);
    check_all("R3 width 7 dropped");
    pulse_a(8);
    model(1'b1);
    check_all("R3 width 8 passes");
    pulse_a(2);
    check_all("R3 width 2 dropped");
    pause(); len_a = 4'd0; resume();
    pulse_a(2);
    model(1'b1);
    check_all("R3 len 0 bypass");
    pause(); fen_a = 1'b0; len_a = 4'd2; resume();
    pulse_a(2);
    model(1'b1);
    check_all("R3 disabled bypass");
    pause(); len_a = 4'd0; resume();

    // R2 latency + R11: clear coincides with a wrap
    pulse_clr();
    while (exp_cnt != HI) begin
      pulse_a(4);
      model(1'b1);
    end
    check_all("R11 at top");
    @(negedge clk); pha = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 no change after 3 edges", int'(cnt), HI);
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
    model(1'b1);
    check_all("R2/R11 wrap beats clear");
    pha = 1'b0; idle(8);
    pulse_clr(); idle(1);
    check("R11 later clear", int'(ovf), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule